// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block holds the control-side state of one four-channel DMA controller in the classic PC layout, reached through a byte-wide I/O port. A port address selects either the address/count window (handled by storage outside this block) or one of eight control registers. The block keeps the command byte, a status byte with per-channel request and terminal-count flags, a per-channel mask, one mode byte per channel with a sequential readback counter, and the low/high byte pointer that the outside address and count storage uses to pick a byte lane.

The same RTL serves both the byte-wide and the word-wide controller of a cascaded pair. A parameter moves the register nibble up by one address bit for the word-wide one, so its control registers sit on even ports and odd ports alias them. Channel request levels and terminal-count pulses come straight from the transfer engine; the mask bits and the byte pointer go back to it.

Top module: `dmac_regfile`

## Requirements
- R1: The register nibble is io_addr[3:0] when WIDE=0 and io_addr[4:1] when WIDE=1; a nibble of 8 or more selects control register index nibble-8, a nibble below 8 selects the address/count window, and other address bits are ignored.
- R2: Reset, or a write to control index 5 (master clear), zeroes the command byte, the status byte and the mode readback counter, sets the byte pointer low and sets every mask bit; stored mode bytes survive a master clear.
- R3: A read of control index 0 returns the status byte {request[3:0], terminal_count[3:0]} and then clears bits 3:0 only.
- R4: A read of control index 1 returns 4'hF in bits 7:4 and status bits 7:4 in bits 3:0.
- R5: Status bit 4+n follows dreq_lvl[n], sampled on each clock edge.
- R6: A tc_pulse[n] sets status bit n; when it arrives in the same cycle as a status read, the read returns the old flags and the bit is still set afterwards.
- R7: A write to control index 3 stores io_wdata as the mode byte of channel io_wdata[1:0]; a read of index 3 returns the mode byte of the channel named by the readback counter ORed with 8'h03 and advances the counter modulo 4; a read of index 6 resets the counter to 0.
- R8: Every read or write in the address/count window toggles byte_hi; a write to control index 4 forces it low and a read of control index 4 forces it high.
- R9: A write to index 2 sets mask bit io_wdata[1:0] to io_wdata[2]; a write to index 6 clears all mask bits; a write to index 7 loads io_wdata[3:0]; a read of index 7 returns {4'hF, mask}.
- R10: A write to control index 0 stores the command byte, which a read of control index 2 returns.
- R11: A write to control index 1 changes nothing; reads of control indices 4 and 6 and of the address/count window return 8'hFF; a read of control index 5 returns 8'h00.
- R12: io_rdata is registered: it takes the read value at the clock edge that samples io_rd and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| dreq_lvl | input | NCH | Per-channel request levels |
| tc_pulse | input | NCH | Per-channel terminal-count set pulses |
| io_rdata | output | 8 | Registered read data |
| chan_mask | output | NCH | Per-channel mask bits |
| byte_hi | output | 1 | Byte pointer, 1 selects the high byte |

## Verification
Every effect of an access lands at the one clock edge that samples the strobe, so read data, mask bits and the byte pointer are due one cycle after the strobe, and a request level shows in the status byte one cycle after it is sampled. The bench drives inputs on falling edges and compares all three outputs against a behavioural model on every falling edge, which is half a cycle after the edge that updated both. Directed checks read a register on one falling edge and compare io_rdata on the next, including the case where a terminal-count pulse and a status read share a cycle.

// File: rtl/dmac_rf_pkg.sv
package dmac_rf_pkg;

   localparam int unsigned DATA_W   = 8;
   localparam int unsigned SLOTS    = 4;
   localparam logic [7:0]  OPEN_BUS = 8'hFF;
   localparam logic [7:0]  TEMP_VAL = 8'h00;

   typedef enum logic [2:0] {
      WR_CMD     = 3'd0,
      WR_REQ     = 3'd1,
      WR_MASK1   = 3'd2,
      WR_MODE    = 3'd3,
      WR_PTRLO   = 3'd4,
      WR_MCLR    = 3'd5,
      WR_MASKCLR = 3'd6,
      WR_MASKALL = 3'd7
   } wr_reg_e;

   typedef enum logic [2:0] {
      RD_STAT   = 3'd0,
      RD_REQ    = 3'd1,
      RD_CMD    = 3'd2,
      RD_MODE   = 3'd3,
      RD_PTRHI  = 3'd4,
      RD_TEMP   = 3'd5,
      RD_CNTCLR = 3'd6,
      RD_MASK   = 3'd7
   } rd_reg_e;

endpackage

// File: rtl/dmac_rf_decode.sv
module dmac_rf_decode #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WIDE   = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [2:0]        idx,
   output logic              ctl_sel,
   output logic              win_sel
);
   logic [3:0] nib;
   logic       unused_addr;

   generate
      if (WIDE != 0) begin : g_word
         assign nib = addr[4:1];
      end else begin : g_byte
         assign nib = addr[3:0];
      end
   endgenerate

   assign unused_addr = ^addr;
   assign ctl_sel     = nib[3];
   assign win_sel     = ~nib[3];
   assign idx         = nib[2:0];
endmodule

// File: rtl/dmac_rf_status.sv
module dmac_rf_status #(
   parameter int unsigned NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mclr,
   input  logic           stat_rd,
   input  logic [NCH-1:0] dreq,
   input  logic [NCH-1:0] tc_set,
   output logic [7:0]     stat
);
   import dmac_rf_pkg::*;

   logic [SLOTS-1:0] tc_flat;
   logic [SLOTS-1:0] rq_flat;

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_ch
         if (k < NCH) begin : g_live
            logic tc_q;
            logic rq_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  tc_q <= 1'b0;
                  rq_q <= 1'b0;
               end else if (mclr) begin
                  tc_q <= 1'b0;
                  rq_q <= 1'b0;
               end else begin
                  // a set in the read cycle wins over the read's clear
                  tc_q <= (tc_q & ~stat_rd) | tc_set[k];
                  rq_q <= dreq[k];
               end
            end
            assign tc_flat[k] = tc_q;
            assign rq_flat[k] = rq_q;
         end else begin : g_void
            assign tc_flat[k] = 1'b0;
            assign rq_flat[k] = 1'b0;
         end
      end
   endgenerate

   assign stat = {rq_flat, tc_flat};
endmodule

// File: rtl/dmac_rf_modes.sv
module dmac_rf_modes #(
   parameter int unsigned NCH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_we,
   input  logic [7:0] wdata,
   input  logic       rb_step,
   input  logic       rb_zero,
   output logic [7:0] rb_data
);
   import dmac_rf_pkg::*;

   localparam int unsigned CNT_W = $clog2(SLOTS);

   logic [SLOTS*DATA_W-1:0] flat;
   logic [CNT_W-1:0]        cnt_q;

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         if (k < NCH) begin : g_live
            logic [DATA_W-1:0] m_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  m_q <= '0;
               end else if (mode_we && (wdata[CNT_W-1:0] == CNT_W'(k))) begin
                  m_q <= wdata;
               end
            end
            assign flat[k*DATA_W +: DATA_W] = m_q;
         end else begin : g_void
            assign flat[k*DATA_W +: DATA_W] = '0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (rb_zero) begin
         cnt_q <= '0;
      end else if (rb_step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign rb_data = flat[cnt_q*DATA_W +: DATA_W] | 8'h03;
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WIDE   = 0,
   parameter int unsigned NCH    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   input  logic [NCH-1:0]    dreq_lvl,
   input  logic [NCH-1:0]    tc_pulse,
   output logic [7:0]        io_rdata,
   output logic [NCH-1:0]    chan_mask,
   output logic              byte_hi
);
   import dmac_rf_pkg::*;

   generate
      if (WIDE > 1) begin : g_bad_wide
         $error("WIDE must be 0 or 1");
      end
      if (NCH < 1 || NCH > SLOTS) begin : g_bad_nch
         $error("NCH must lie in 1..4");
      end
      if (ADDR_W < 4 + WIDE) begin : g_bad_addr
         $error("ADDR_W too narrow for the register nibble");
      end
   endgenerate

   logic [2:0]       idx;
   logic             ctl_sel;
   logic             win_sel;
   logic             wr_hit;
   logic             rd_hit;
   wr_reg_e          widx;
   rd_reg_e          ridx;
   logic             mclr;
   logic [7:0]       stat;
   logic [7:0]       mode_rb;
   logic [7:0]       cmd_q;
   logic [SLOTS-1:0] mask_pad;
   logic             ptr_q;
   logic [7:0]       rsel;
   logic [7:0]       rdata_q;

   dmac_rf_decode #(.ADDR_W(ADDR_W), .WIDE(WIDE)) u_dec (
      .addr    (io_addr),
      .idx     (idx),
      .ctl_sel (ctl_sel),
      .win_sel (win_sel)
   );

   assign wr_hit = io_wr & ctl_sel;
   assign rd_hit = io_rd & ctl_sel;
   assign widx   = wr_reg_e'(idx);
   assign ridx   = rd_reg_e'(idx);
   assign mclr   = wr_hit && (widx == WR_MCLR);

   dmac_rf_status #(.NCH(NCH)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .mclr    (mclr),
      .stat_rd (rd_hit && (ridx == RD_STAT)),
      .dreq    (dreq_lvl),
      .tc_set  (tc_pulse),
      .stat    (stat)
   );

   dmac_rf_modes #(.NCH(NCH)) u_modes (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_we (wr_hit && (widx == WR_MODE)),
      .wdata   (io_wdata),
      .rb_step (rd_hit && (ridx == RD_MODE)),
      .rb_zero (mclr || (rd_hit && (ridx == RD_CNTCLR))),
      .rb_data (mode_rb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (mclr) begin
         cmd_q <= '0;
      end else if (wr_hit && (widx == WR_CMD)) begin
         cmd_q <= io_wdata;
      end
   end

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_mask
         if (k < NCH) begin : g_live
            logic m_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  m_q <= 1'b1;
               end else if (mclr) begin
                  m_q <= 1'b1;
               end else if (wr_hit) begin
                  case (widx)
                     WR_MASKCLR: m_q <= 1'b0;
                     WR_MASKALL: m_q <= io_wdata[k];
                     WR_MASK1:   if (io_wdata[1:0] == 2'(k)) m_q <= io_wdata[2];
                     default:    m_q <= m_q;
                  endcase
               end
            end
            assign mask_pad[k] = m_q;
         end else begin : g_void
            assign mask_pad[k] = 1'b1;
         end
      end
   endgenerate

   assign chan_mask = mask_pad[NCH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= 1'b0;
      end else if (mclr || (wr_hit && (widx == WR_PTRLO))) begin
         ptr_q <= 1'b0;
      end else if (rd_hit && (ridx == RD_PTRHI)) begin
         ptr_q <= 1'b1;
      end else if (win_sel && (io_rd || io_wr)) begin
         ptr_q <= ~ptr_q;
      end
   end

   assign byte_hi = ptr_q;

   always_comb begin
      case (ridx)
         RD_STAT: rsel = stat;
         RD_REQ:  rsel = {4'hF, stat[7:4]};
         RD_CMD:  rsel = cmd_q;
         RD_MODE: rsel = mode_rb;
         RD_TEMP: rsel = TEMP_VAL;
         RD_MASK: rsel = {4'hF, mask_pad};
         default: rsel = OPEN_BUS;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (io_rd) begin
         rdata_q <= ctl_sel ? rsel : OPEN_BUS;
      end
   end

   assign io_rdata = rdata_q;
endmodule

// File: rtl/dmac_rf_chk.sv
module dmac_rf_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WIDE   = 0,
   parameter int unsigned NCH    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_rd,
   input logic              io_wr,
   input logic [7:0]        io_wdata,
   input logic [NCH-1:0]    dreq_lvl,
   input logic [NCH-1:0]    tc_pulse,
   input logic [7:0]        io_rdata,
   input logic [NCH-1:0]    chan_mask,
   input logic              byte_hi
);
   logic [3:0] nib;
   logic       ctl;
   logic [2:0] ix;
   logic       unused_chk;

   assign nib        = io_addr[WIDE +: 4];
   assign ctl        = nib[3];
   assign ix         = nib[2:0];
   assign unused_chk = ^{io_addr, io_wdata, dreq_lvl, tc_pulse};

   assert_mask_set_on_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && ctl && ix == 3'd5) |=> (chan_mask == {NCH{1'b1}}));

   assert_ptr_low_on_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && ctl && ix == 3'd5) |=> !byte_hi);

   assert_req_upper_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && ctl && ix == 3'd1) |=> (io_rdata[7:4] == 4'hF));

   assert_mode_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && ctl && ix == 3'd3) |=> (io_rdata[1:0] == 2'b11));

   assert_ptr_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_rd || io_wr) && !ctl) |=> (byte_hi != $past(byte_hi)));

   assert_ptr_low_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_rd && ctl && ix == 3'd4) |=> !byte_hi);

   assert_open_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && (!ctl || ix == 3'd4 || ix == 3'd6)) |=> (io_rdata == 8'hFF));

   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> $stable(io_rdata));
endmodule

bind dmac_regfile dmac_rf_chk #(.ADDR_W(ADDR_W), .WIDE(WIDE), .NCH(NCH)) u_chk (.*);

// File: tb/tb_dmac_regfile.sv
`timescale 1ns/1ps
module tb_dmac_regfile;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] io_addr = '0;
   logic       io_rd = 1'b0;
   logic       io_wr = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [3:0] dreq_lvl = '0;
   logic [3:0] tc_pulse = '0;
   logic [7:0] io_rdata;
   logic [3:0] chan_mask;
   logic       byte_hi;

   logic [7:0] w_addr = '0;
   logic       w_rd = 1'b0;
   logic       w_wr = 1'b0;
   logic [7:0] w_wdata = '0;
   logic [7:0] w_rdata;
   logic [3:0] w_mask;
   logic       w_hi;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dmac_regfile #(.ADDR_W(8), .WIDE(0), .NCH(4)) dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .dreq_lvl(dreq_lvl), .tc_pulse(tc_pulse),
      .io_rdata(io_rdata), .chan_mask(chan_mask), .byte_hi(byte_hi)
   );

   dmac_regfile #(.ADDR_W(8), .WIDE(1), .NCH(4)) dut_w (
      .clk(clk), .rst_n(rst_n), .io_addr(w_addr), .io_rd(w_rd), .io_wr(w_wr),
      .io_wdata(w_wdata), .dreq_lvl(4'h0), .tc_pulse(4'h0),
      .io_rdata(w_rdata), .chan_mask(w_mask), .byte_hi(w_hi)
   );

   // behavioural reference of the byte-wide instance
   int m_cmd, m_cnt, m_rd;
   int m_mode [4];
   bit m_tc [4];
   bit m_rq [4];
   bit m_mask [4];
   bit m_ptr;

   function automatic int m_stat();
      int s = 0;
      for (int i = 0; i < 4; i++) begin
         if (m_tc[i]) s += (1 << i);
         if (m_rq[i]) s += (1 << (i + 4));
      end
      return s;
   endfunction

   function automatic int m_maskval();
      int s = 0;
      for (int i = 0; i < 4; i++) if (m_mask[i]) s += (1 << i);
      return s;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cmd = 0; m_cnt = 0; m_rd = 0; m_ptr = 0;
         for (int i = 0; i < 4; i++) begin
            m_mode[i] = 0; m_tc[i] = 0; m_rq[i] = 0; m_mask[i] = 1;
         end
      end else begin
         int nib, r;
         bit ctl, sread, mc;
         nib = int'(io_addr) % 16;
         ctl = (nib >= 8);
         r = nib - 8;
         sread = io_rd && ctl && r == 0;
         mc = io_wr && ctl && r == 5;
         if (io_rd) begin
            if (!ctl) m_rd = 255;
            else case (r)
               0: m_rd = m_stat();
               1: m_rd = 240 + m_stat() / 16;
               2: m_rd = m_cmd;
               3: begin m_rd = m_mode[m_cnt] | 3; m_cnt = (m_cnt + 1) % 4; end
               4: begin m_rd = 255; m_ptr = 1; end
               5: m_rd = 0;
               6: begin m_rd = 255; m_cnt = 0; end
               default: m_rd = 240 + m_maskval();
            endcase
         end
         if (io_wr && ctl) begin
            case (r)
               0: m_cmd = int'(io_wdata);
               2: m_mask[io_wdata[1:0]] = io_wdata[2];
               3: m_mode[io_wdata[1:0]] = int'(io_wdata);
               4: m_ptr = 0;
               6: for (int i = 0; i < 4; i++) m_mask[i] = 0;
               7: for (int i = 0; i < 4; i++) m_mask[i] = io_wdata[i];
               default: ;
            endcase
         end
         if (!ctl && (io_rd || io_wr)) m_ptr = !m_ptr;
         for (int i = 0; i < 4; i++) begin
            m_tc[i] = (m_tc[i] && !sread) || tc_pulse[i];
            m_rq[i] = dreq_lvl[i];
         end
         if (mc) begin
            m_cmd = 0; m_cnt = 0; m_ptr = 0;
            for (int i = 0; i < 4; i++) begin
               m_tc[i] = 0; m_rq[i] = 0; m_mask[i] = 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         checks += 3;
         if (int'(io_rdata) != m_rd) begin
            errors++;
            $display("FAIL R12 model io_rdata act %h exp %h", io_rdata, m_rd[7:0]);
         end
         if (int'(chan_mask) != m_maskval()) begin
            errors++;
            $display("FAIL R9 model chan_mask act %h exp %h", chan_mask, m_maskval());
         end
         if (byte_hi != m_ptr) begin
            errors++;
            $display("FAIL R8 model byte_hi act %0d exp %0d", byte_hi, m_ptr);
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act %h exp %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      chk(tag, io_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      idle(1);
      // R2 reset state
      chk("R2 reset mask", {4'h0, chan_mask}, 8'h0F);
      chk("R2 reset ptr", {7'h0, byte_hi}, 8'h00);
      rd_chk(8'h08, 8'h00, "R3 status after reset");
      // R10 command
      wr(8'h08, 8'h5A);
      rd_chk(8'h0A, 8'h5A, "R10 command readback");
      // R5 request levels, R4 request view
      dreq_lvl = 4'b0101;
      idle(2);
      rd_chk(8'h08, 8'h50, "R5 status request bits");
      rd_chk(8'h09, 8'hF5, "R4 request view");
      // R6 and R3 terminal count
      tc_pulse = 4'b0011;
      idle(1);
      tc_pulse = 4'b0000;
      rd_chk(8'h08, 8'h53, "R6 tc set");
      rd_chk(8'h08, 8'h50, "R3 tc cleared by read");
      io_addr = 8'h08; io_rd = 1'b1; tc_pulse = 4'b1000;
      @(negedge clk);
      io_rd = 1'b0; tc_pulse = 4'b0000;
      chk("R6 read alongside pulse", io_rdata, 8'h50);
      rd_chk(8'h08, 8'h58, "R6 pulse survives read");
      rd_chk(8'h08, 8'h50, "R3 second clear");
      dreq_lvl = 4'b0000;
      idle(2);
      rd_chk(8'h09, 8'hF0, "R5 request dropped");
      // R7 modes
      wr(8'h0B, 8'h44);
      wr(8'h0B, 8'h89);
      wr(8'h0B, 8'h12);
      wr(8'h0B, 8'hC3);
      rd_chk(8'h0B, 8'h47, "R7 mode ch0");
      rd_chk(8'h0B, 8'h8B, "R7 mode ch1");
      rd_chk(8'h0B, 8'h13, "R7 mode ch2");
      rd_chk(8'h0B, 8'hC3, "R7 mode ch3");
      rd_chk(8'h0B, 8'h47, "R7 counter wraps");
      rd_chk(8'h0E, 8'hFF, "R11 counter reset reads open");
      rd_chk(8'h0B, 8'h47, "R7 counter reset");
      // R9 mask
      wr(8'h0A, 8'h01);
      rd_chk(8'h0F, 8'hFD, "R9 single mask clear");
      wr(8'h0A, 8'h04);
      wr(8'h0E, 8'h00);
      rd_chk(8'h0F, 8'hF0, "R9 clear all");
      wr(8'h0F, 8'h06);
      chk("R9 load all", {4'h0, chan_mask}, 8'h06);
      // R8 byte pointer
      wr(8'h02, 8'h11);
      chk("R8 window write toggles", {7'h0, byte_hi}, 8'h01);
      rd_chk(8'h03, 8'hFF, "R11 window read open");
      chk("R8 window read toggles", {7'h0, byte_hi}, 8'h00);
      rd_chk(8'h0C, 8'hFF, "R11 set-pointer read open");
      chk("R8 set pointer", {7'h0, byte_hi}, 8'h01);
      wr(8'h0C, 8'h00);
      chk("R8 clear pointer", {7'h0, byte_hi}, 8'h00);
      // R11 ignored write, temp
      wr(8'h09, 8'h04);
      rd_chk(8'h09, 8'hF0, "R11 request write ignored");
      rd_chk(8'h08, 8'h00, "R11 status untouched");
      rd_chk(8'h0D, 8'h00, "R11 temp reads zero");
      // R2 master clear
      wr(8'h01, 8'h00);
      rd_chk(8'h0B, 8'h8B, "R7 counter advanced");
      tc_pulse = 4'b0100;
      idle(1);
      tc_pulse = 4'b0000;
      wr(8'h0D, 8'h00);
      chk("R2 clear mask", {4'h0, chan_mask}, 8'h0F);
      chk("R2 clear ptr", {7'h0, byte_hi}, 8'h00);
      rd_chk(8'h08, 8'h00, "R2 clear status");
      rd_chk(8'h0A, 8'h00, "R2 clear command");
      rd_chk(8'h0B, 8'h47, "R2 counter zero modes kept");
      // R12 hold
      idle(3);
      chk("R12 rdata holds", io_rdata, 8'h47);
      // R1 decode
      wr(8'h08, 8'h77);
      rd_chk(8'h1A, 8'h77, "R1 high bits ignored");
      w_addr = 8'h10; w_wdata = 8'h3C; w_wr = 1'b1;
      @(negedge clk);
      w_wr = 1'b0;
      w_addr = 8'h15; w_rd = 1'b1;
      @(negedge clk);
      w_rd = 1'b0;
      chk("R1 word controller command", w_rdata, 8'h3C);
      w_addr = 8'h11; w_rd = 1'b1;
      @(negedge clk);
      w_rd = 1'b0;
      chk("R1 word controller odd alias", w_rdata, 8'h00);
      idle(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule